// File: doc/BRIEF.md
# Binary to Decimal Text Converter

This block turns an unsigned binary integer into its decimal character string, the same text a `%d` print of the number would give. A one-cycle start pulse loads the value. The engine then emits one decimal digit per clock by repeated division by ten. The divider is a multiply by a fixed scaled reciprocal followed by a shift, so no iterative divider is needed. Remainders arrive least significant first and are kept in a small register array. The array is read back in the reverse order, so the output bus shows the most significant character first.

When the quotient reaches zero the block stops. It raises a one-cycle done flag and holds the digit count and the text until the next accepted start. For the default 32-bit width a conversion takes at most eleven clocks. At 200 MHz that is far below a five-microsecond budget.

Top module: `dec_ascii_conv`

## Requirements
- R1: After reset, `busy`, `done` and `num_digits` are all zero.
- R2: Each character equals 0x30 plus its decimal digit. Character k, counted from the most significant (k = 0), sits at `text[8k+7:8k]`. Every position k at or above `num_digits` reads 0x00.
- R3: An input of zero gives the single character "0" (0x30) and `num_digits` = 1.
- R4: Leading zeros are suppressed. `num_digits` equals the number of decimal digits of the value, and the first character is never "0" when more than one digit is present.
- R5: One digit is produced per clock. If a start is accepted at clock edge e0, `done` is high in the cycle after edge e(num_digits).
- R6: `done` is high for exactly one cycle per conversion.
- R7: A start pulse that arrives while `busy` is high is ignored. The running conversion completes with the original value.
- R8: The all-ones input (4294967295 at the default width) gives ten characters, which is the maximum.
- R9: While idle and with `start` low, `num_digits` and `text` hold their values.
- R10: `busy` goes high in the cycle after an accepted start and stays high until the final digit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to convert `value`; only accepted while idle |
| value | input | VAL_W | Unsigned integer to convert |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the text is complete |
| num_digits | output | CNT_W | Number of valid characters |
| text | output | DIG_N*8 | Characters, most significant at the lowest byte, unused bytes zero |

## Verification
The bench builds the block at its default 32-bit width, which gives a ten-character buffer and a 4-bit count. At this width the reciprocal constant 0xCCCCCCCD and the 35-bit shift are exercised across the full input range, including the all-ones value that fills every buffer slot. The random values are shifted right by random amounts, so every digit count from one to ten appears often. This covers the reciprocal's worst-case rounding near powers of ten and the latency of every conversion length.

// File: rtl/dec_ascii_pkg.sv
`timescale 1ns/1ps
package dec_ascii_pkg;

    // Decimal digits needed for 2**w - 1 (log10(2) ~ 0.30103)
    function automatic int unsigned max_digits(input int unsigned w);
        return (w * 30103) / 100000 + 1;
    endfunction

    function automatic logic [7:0] digit_char(input logic [3:0] d);
        return 8'h30 + {4'h0, d};
    endfunction

endpackage

// File: rtl/dec_div10.sv
`timescale 1ns/1ps
module dec_div10 #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] q,
    output logic [3:0]   r
);
    // Scaled reciprocal ceil(2**(W+3)/10); its error term stays below 8,
    // so floor(x*RECIP / 2**(W+3)) equals floor(x/10) for every W-bit x.
    localparam int unsigned SH = W + 3;
    localparam logic [W+3:0] SCALE      = {1'b1, {(W+3){1'b0}}};
    localparam logic [W+3:0] RECIP_WIDE = (SCALE + (W+4)'(9)) / (W+4)'(10);
    localparam logic [W-1:0] RECIP      = RECIP_WIDE[W-1:0];

    logic [2*W-1:0] prod;
    logic [W-1:0]   back;

    always_comb begin
        prod = {{W{1'b0}}, x} * {{W{1'b0}}, RECIP};
        q    = W'(prod >> SH);
        back = q * W'(10);
        r    = 4'(x - back);
    end
endmodule

// File: rtl/dec_char_store.sv
`timescale 1ns/1ps
module dec_char_store #(
    parameter int unsigned DIG_N = 10,
    parameter int unsigned CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_idx,
    input  logic [7:0]         wr_char,
    input  logic [CNT_W-1:0]   rd_cnt,
    output logic [DIG_N*8-1:0] text
);
    logic [7:0] mem_q [DIG_N];
    logic [7:0] mem_d [DIG_N];

    always_comb begin
        for (int i = 0; i < DIG_N; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && (int'(wr_idx) < DIG_N)) begin
            mem_d[wr_idx] = wr_char;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DIG_N; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < DIG_N; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // Reverse order on read: slot 0 holds the least significant digit
    for (genvar k = 0; k < DIG_N; k++) begin : g_rd
        logic [CNT_W-1:0] src;
        assign src = rd_cnt - CNT_W'(k + 1);
        assign text[8*k +: 8] = (k < int'(rd_cnt)) ? mem_q[src] : 8'h00;
    end
endmodule

// File: rtl/dec_ascii_conv.sv
`timescale 1ns/1ps
module dec_ascii_conv
    import dec_ascii_pkg::*;
#(
    parameter int unsigned VAL_W = 32,
    localparam int unsigned DIG_N = max_digits(VAL_W),
    localparam int unsigned CNT_W = $clog2(DIG_N + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VAL_W-1:0]   value,
    output logic               busy,
    output logic               done,
    output logic [CNT_W-1:0]   num_digits,
    output logic [DIG_N*8-1:0] text
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [VAL_W-1:0] work;
        logic [CNT_W-1:0] cnt;
    } conv_st_t;

    conv_st_t   st_d, st_q;
    logic [VAL_W-1:0] quo;
    logic [3:0]       rem;
    logic             wr_en;

    dec_div10 #(.W(VAL_W)) u_div (
        .x (st_q.work),
        .q (quo),
        .r (rem)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wr_en     = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.work = value;
                st_d.cnt  = '0;
            end
        end else begin
            wr_en     = 1'b1;
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.work = quo;
            if (quo == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dec_char_store #(.DIG_N(DIG_N), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (st_q.cnt),
        .wr_char (digit_char(rem)),
        .rd_cnt  (st_q.cnt),
        .text    (text)
    );

    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign num_digits = st_q.cnt;
endmodule

// File: rtl/dec_ascii_conv_chk.sv
`timescale 1ns/1ps
module dec_ascii_conv_chk #(
    parameter int unsigned DIG_N = 10,
    parameter int unsigned CNT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [CNT_W-1:0]   num_digits,
    input logic [DIG_N*8-1:0] text
);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_follows_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_digit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (num_digits == $past(num_digits) + CNT_W'(1)));

    p_busy_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(num_digits) && $stable(text)));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(num_digits) <= DIG_N);

    p_no_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && num_digits > CNT_W'(1)) |-> (text[7:0] != 8'h30));

    for (genvar k = 0; k < DIG_N; k++) begin : g_chr
        p_char_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (done && (k < int'(num_digits))) |->
            (text[8*k +: 8] >= 8'h30 && text[8*k +: 8] <= 8'h39));
        p_char_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (done && (k >= int'(num_digits))) |-> (text[8*k +: 8] == 8'h00));
    end
endmodule

bind dec_ascii_conv dec_ascii_conv_chk #(.DIG_N(DIG_N), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .num_digits (num_digits),
    .text       (text)
);

// File: tb/dec_ascii_conv_bench.sv
`timescale 1ns/1ps
module dec_ascii_conv_bench;
    localparam int W     = 32;
    localparam int DIG_N = 10;
    localparam int CNT_W = 4;
    localparam int TXT_W = DIG_N * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     value = '0;
    logic             busy, done;
    logic [CNT_W-1:0] num_digits;
    logic [TXT_W-1:0] text;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dec_ascii_conv #(.VAL_W(W)) u_dec_ascii_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .value(value),
        .busy(busy), .done(done), .num_digits(num_digits), .text(text)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [W-1:0] v);
        int n = 1;
        while (v >= 10) begin
            v = v / 10;
            n++;
        end
        return n;
    endfunction

    function automatic logic [TXT_W-1:0] exp_text(input logic [W-1:0] v);
        logic [TXT_W-1:0] t = '0;
        int n = exp_len(v);
        for (int i = n - 1; i >= 0; i--) begin
            t[8*i +: 8] = 8'h30 + 8'(v % 10);
            v = v / 10;
        end
        return t;
    endfunction

    task automatic convert(input logic [W-1:0] v, input bit inject, input string tag);
        int lat;
        logic [TXT_W-1:0] et;
        int en;
        et = exp_text(v);
        en = exp_len(v);
        @(negedge clk);
        start = 1'b1;
        value = v;
        @(negedge clk);
        start = 1'b0;
        value = $urandom;
        lat = 1;
        chk(busy == 1'b1, "R10 busy after start", 128'(busy), 128'(1));
        if (inject) begin
            start = 1'b1;   // R7: pulse while busy must be ignored
            value = ~v;
        end
        while (!done && lat < 60) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(lat == en + 1, {"R5 latency ", tag}, 128'(lat), 128'(en + 1));
        chk(int'(num_digits) == en, {"R4 digit count ", tag}, 128'(num_digits), 128'(en));
        chk(text == et, {inject ? "R7 text after ignored start " : "R2 text ", tag},
            128'(text), 128'(et));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R6 done single cycle",
            128'({busy, done}), 128'(0));
        repeat (2) begin
            value = $urandom;
            @(negedge clk);
        end
        chk(text == et && int'(num_digits) == en, "R9 hold while idle",
            128'(text), 128'(et));
    endtask

    initial begin
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && num_digits == 0, "R1 reset state",
            128'({busy, done, num_digits}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && num_digits == 0, "R1 after reset release",
            128'({busy, done, num_digits}), 128'(0));

        convert(32'd0, 1'b0, "R3 zero");
        chk(text[7:0] == 8'h30 && num_digits == 1, "R3 zero single char",
            128'(text), 128'h30);
        convert(32'd1, 1'b0, "one");
        convert(32'd9, 1'b0, "nine");
        convert(32'd10, 1'b0, "ten");
        convert(32'd99, 1'b0, "99");
        convert(32'd100, 1'b0, "100");
        convert(32'd999999999, 1'b0, "nine nines");
        convert(32'd1000000000, 1'b0, "1e9");
        convert(32'hFFFFFFFF, 1'b0, "R8 all ones");
        chk(num_digits == 10, "R8 ten characters", 128'(num_digits), 128'(10));
        convert(32'd5, 1'b1, "R7 short");
        convert(32'd4000000000, 1'b1, "R7 long");

        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] rv;
            rv = $urandom >> ($urandom % 32);
            convert(rv, (i % 7) == 3, "random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule